// File: doc/BRIEF.md
# Output Pixel Packer

The packer takes a stream of 32-bit ARGB pixels and turns each one into a word laid out in one of five memory formats. These formats cover 32-bit, 24-bit and 16-bit layouts. Before packing, three optional adjustments can be applied: the alpha channel can be inverted, red and blue can be exchanged, and the bytes of the packed word can be swapped in pairs. Each output word carries a count of how many of its low bytes are meaningful. A downstream writer uses that count to advance its address.

A fill mode replaces the input stream with a constant colour taken from a configuration input. In this mode the packer emits that colour on every cycle in which the output can take a word. Input and output are valid/ready streams. One register stage sits on the output, and it holds its word while the consumer stalls. A format code the packer does not know raises a configuration error, and the stream stops accepting pixels.

Top module: `pix_out_packer`

## Requirements
- R1: After reset, out_valid_o is 0.
- R2: Format 0 packs to {A,R,G,B} with A in bits 31:24 and B in bits 7:0. Format 1 packs to {8'h00,R,G,B}.
- R3: The 16-bit formats keep the top bits of each channel, with bits 31:16 zero. Format 2 is R[7:3],G[7:2],B[7:3]. Format 3 is A[7],R[7:3],G[7:3],B[7:3]. Format 4 is A[7:4],R[7:4],G[7:4],B[7:4], listed from bit 15 down.
- R4: out_bytes_o is 4 for format 0, 3 for format 1, and 2 for formats 2, 3 and 4.
- R5: With alpha_inv_i set, alpha is replaced by 255 minus alpha before packing.
- R6: With rb_swap_i set, the red and blue channels are exchanged before packing.
- R7: With byte_swap_i set, byte lanes 0 and 1 of the packed word are exchanged, and so are lanes 2 and 3. This happens after packing.
- R8: With fill_en_i set, fill_color_i is used as the source pixel (B in bits 7:0, G in 15:8, R in 23:16, A in 31:24). The adjustments still apply. in_ready_o is 0 and in_pixel_i has no effect.
- R9: Format codes 5, 6 and 7 set cfg_err_o and hold in_ready_o at 0. No new word is produced while the code is invalid.
- R10: A pixel accepted on a rising edge is on the output after that edge. While out_valid_o is 1 and out_ready_i is 0, the output word, its byte count and its valid flag hold, and in_ready_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fmt_i | input | 3 | Output format code |
| alpha_inv_i | input | 1 | Invert alpha before packing |
| rb_swap_i | input | 1 | Exchange red and blue |
| byte_swap_i | input | 1 | Swap bytes in pairs after packing |
| fill_en_i | input | 1 | Use the constant fill colour as the source |
| fill_color_i | input | 32 | Fill colour, ARGB |
| in_valid_i | input | 1 | Input pixel valid |
| in_ready_o | output | 1 | Input pixel accepted |
| in_pixel_i | input | 32 | Input pixel, ARGB |
| out_valid_o | output | 1 | Output word valid |
| out_ready_i | input | 1 | Consumer takes the output word |
| out_data_o | output | 32 | Packed word |
| out_bytes_o | output | 3 | Number of meaningful low bytes |
| cfg_err_o | output | 1 | Format code is invalid |

## Verification
The packed word and its byte count come out one rising edge after the pixel is accepted. The bench therefore drives on a falling edge and checks at the next falling edge. cfg_err_o and in_ready_o are combinational from the configuration, so they are checked a short delay after the drive in the same cycle. For the stall case the bench holds out_ready_i low for several cycles and compares the output on each falling edge. Fill mode is observed on consecutive falling edges while the input carries a different pixel.

// File: rtl/pix_pack_pkg.sv
package pix_pack_pkg;
  localparam int CHAN_W = 8;
  localparam int LANES  = 4;
  localparam int WORD_W = CHAN_W * LANES;
  localparam int CNT_W  = 3;

  typedef enum logic [2:0] {
    FMT_ARGB32   = 3'd0,
    FMT_RGB24    = 3'd1,
    FMT_RGB565   = 3'd2,
    FMT_ARGB1555 = 3'd3,
    FMT_ARGB4444 = 3'd4
  } out_fmt_e;

  typedef struct packed {
    logic [CHAN_W-1:0] a;
    logic [CHAN_W-1:0] r;
    logic [CHAN_W-1:0] g;
    logic [CHAN_W-1:0] b;
  } argb_t;
endpackage

// File: rtl/pix_chan_adjust.sv
module pix_chan_adjust
  import pix_pack_pkg::*;
(
  input  logic  fill_en_i,
  input  argb_t fill_px_i,
  input  argb_t in_px_i,
  input  logic  alpha_inv_i,
  input  logic  rb_swap_i,
  output argb_t px_o
);
  argb_t src;
  always_comb begin
    src     = fill_en_i ? fill_px_i : in_px_i;
    px_o.a  = alpha_inv_i ? ~src.a : src.a;  // 255 - a
    px_o.g  = src.g;
    px_o.r  = rb_swap_i ? src.b : src.r;
    px_o.b  = rb_swap_i ? src.r : src.b;
  end
endmodule

// File: rtl/pix_fmt_pack.sv
module pix_fmt_pack
  import pix_pack_pkg::*;
(
  input  argb_t              px_i,
  input  logic [2:0]         fmt_i,
  output logic [WORD_W-1:0]  word_o,
  output logic [CNT_W-1:0]   nbytes_o,
  output logic               bad_o
);
  always_comb begin
    word_o   = '0;
    nbytes_o = 3'd2;
    bad_o    = 1'b0;
    case (fmt_i)
      FMT_ARGB32: begin
        word_o   = {px_i.a, px_i.r, px_i.g, px_i.b};
        nbytes_o = 3'd4;
      end
      FMT_RGB24: begin
        word_o   = {8'h00, px_i.r, px_i.g, px_i.b};
        nbytes_o = 3'd3;
      end
      FMT_RGB565:
        word_o[15:0] = {px_i.r[7:3], px_i.g[7:2], px_i.b[7:3]};
      FMT_ARGB1555:
        word_o[15:0] = {px_i.a[7], px_i.r[7:3], px_i.g[7:3], px_i.b[7:3]};
      FMT_ARGB4444:
        word_o[15:0] = {px_i.a[7:4], px_i.r[7:4], px_i.g[7:4], px_i.b[7:4]};
      default: begin
        nbytes_o = '0;
        bad_o    = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/pix_lane_swap.sv
module pix_lane_swap
  import pix_pack_pkg::*;
(
  input  logic              en_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] word_o
);
  for (genvar p = 0; p < LANES / 2; p++) begin : g_pair
    localparam int LO = 2 * p * CHAN_W;
    localparam int HI = LO + CHAN_W;
    assign word_o[LO +: CHAN_W] = en_i ? word_i[HI +: CHAN_W] : word_i[LO +: CHAN_W];
    assign word_o[HI +: CHAN_W] = en_i ? word_i[LO +: CHAN_W] : word_i[HI +: CHAN_W];
  end
endmodule

// File: rtl/pix_out_packer.sv
module pix_out_packer
  import pix_pack_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        fmt_i,
  input  logic              alpha_inv_i,
  input  logic              rb_swap_i,
  input  logic              byte_swap_i,
  input  logic              fill_en_i,
  input  logic [WORD_W-1:0] fill_color_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [WORD_W-1:0] in_pixel_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [WORD_W-1:0] out_data_o,
  output logic [CNT_W-1:0]  out_bytes_o,
  output logic              cfg_err_o
);
  argb_t             adj_px;
  logic [WORD_W-1:0] packed_w, swapped_w;
  logic [CNT_W-1:0]  nbytes;
  logic              space, src_valid, load;

  pix_chan_adjust u_adj (
    .fill_en_i  (fill_en_i),
    .fill_px_i  (argb_t'(fill_color_i)),
    .in_px_i    (argb_t'(in_pixel_i)),
    .alpha_inv_i(alpha_inv_i),
    .rb_swap_i  (rb_swap_i),
    .px_o       (adj_px)
  );

  pix_fmt_pack u_pack (
    .px_i    (adj_px),
    .fmt_i   (fmt_i),
    .word_o  (packed_w),
    .nbytes_o(nbytes),
    .bad_o   (cfg_err_o)
  );

  pix_lane_swap u_swap (
    .en_i  (byte_swap_i),
    .word_i(packed_w),
    .word_o(swapped_w)
  );

  assign space      = !out_valid_o || out_ready_i;
  assign src_valid  = !cfg_err_o && (fill_en_i || in_valid_i);
  assign load       = space && src_valid;
  assign in_ready_o = space && !cfg_err_o && !fill_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
      out_bytes_o <= '0;
    end else if (space) begin
      out_valid_o <= src_valid;
      if (load) begin
        out_data_o  <= swapped_w;
        out_bytes_o <= nbytes;
      end
    end
  end

  // R10
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o) && $stable(out_bytes_o));
  // R9
  cfg_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> !in_ready_o);
  // R8
  fill_flow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_en_i && !cfg_err_o && space |=> out_valid_o);
  // R4
  byte_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> out_bytes_o inside {3'd2, 3'd3, 3'd4});
  // R3
  half_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_bytes_o == 3'd2 |-> out_data_o[31:16] == 16'h0);
endmodule

// File: tb/pix_out_packer_test.sv
module pix_out_packer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  fmt = 3'd0;
  logic        ainv = 1'b0, rbs = 1'b0, bsw = 1'b0, fill = 1'b0;
  logic [31:0] fill_col = 32'h0;
  logic        in_valid = 1'b0, out_ready = 1'b1;
  logic [31:0] in_pix = 32'h0;
  logic        in_ready, out_valid, cfg_err;
  logic [31:0] out_data;
  logic [2:0]  out_bytes;
  int          checks = 0, fails = 0;
  bit          done = 1'b0;

  localparam logic [31:0] PIX = 32'hC8F08818;

  always #2 clk = ~clk;

  pix_out_packer uut (
    .clk_i(clk), .rst_ni(rst_n), .fmt_i(fmt), .alpha_inv_i(ainv), .rb_swap_i(rbs),
    .byte_swap_i(bsw), .fill_en_i(fill), .fill_color_i(fill_col),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_pixel_i(in_pix),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data),
    .out_bytes_o(out_bytes), .cfg_err_o(cfg_err)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // send one pixel and check word and byte count one edge later
  task automatic send(string req, logic [2:0] f, logic ai, logic rs, logic bs,
                      logic [31:0] exp_w, logic [2:0] exp_n);
    @(negedge clk);
    fmt = f; ainv = ai; rbs = rs; bsw = bs;
    in_pix = PIX; in_valid = 1'b1; out_ready = 1'b1;
    #1 chk({req, " in_ready"}, 32'(in_ready), 32'd1);
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " valid"}, 32'(out_valid), 32'd1);
    chk({req, " data"}, out_data, exp_w);
    chk({req, " bytes"}, 32'(out_bytes), 32'(exp_n));
    @(negedge clk);
    ainv = 1'b0; rbs = 1'b0; bsw = 1'b0; fmt = 3'd0;
  endtask

  task automatic t_reset;
    chk("R1 reset valid", 32'(out_valid), 32'd0);
  endtask

  task automatic t_formats;
    send("R2 argb32", 3'd0, 0, 0, 0, 32'hC8F08818, 3'd4);
    send("R2 rgb24 R4", 3'd1, 0, 0, 0, 32'h00F08818, 3'd3);
    send("R3 rgb565 R4", 3'd2, 0, 0, 0, 32'h0000F443, 3'd2);
    send("R3 argb1555", 3'd3, 0, 0, 0, 32'h0000FA23, 3'd2);
    send("R3 argb4444", 3'd4, 0, 0, 0, 32'h0000CF81, 3'd2);
  endtask

  task automatic t_adjust;
    send("R5 alpha inv", 3'd0, 1, 0, 0, 32'h37F08818, 3'd4);
    send("R5 alpha inv 1555", 3'd3, 1, 0, 0, 32'h00007A23, 3'd2);
    send("R6 rb swap", 3'd0, 0, 1, 0, 32'hC81888F0, 3'd4);
    send("R6 rb swap 565", 3'd2, 0, 1, 0, 32'h00001C5E, 3'd2);
    send("R7 byte swap", 3'd0, 0, 0, 1, 32'hF0C81888, 3'd4);
    send("R7 byte swap 565", 3'd2, 0, 0, 1, 32'h000043F4, 3'd2);
    send("R7 byte swap rgb24", 3'd1, 0, 0, 1, 32'hF0001888, 3'd3);
  endtask

  task automatic t_fill;
    @(negedge clk);
    fill_col = 32'h11223344; fill = 1'b1; fmt = 3'd0;
    in_pix = PIX; in_valid = 1'b1; out_ready = 1'b1;
    #1 chk("R8 in_ready low", 32'(in_ready), 32'd0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R8 fill valid", 32'(out_valid), 32'd1);
      chk("R8 fill data", out_data, 32'h11223344);
    end
    fmt = 3'd4;
    @(negedge clk);
    chk("R8 fill 4444", out_data, 32'h00001234);
    fmt = 3'd0; ainv = 1'b1;
    @(negedge clk);
    chk("R8 R5 fill inv", out_data, 32'hEE223344);
    fill = 1'b0; ainv = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    chk("R8 fill off", 32'(out_valid), 32'd0);
  endtask

  task automatic t_cfg_err;
    @(negedge clk);
    out_ready = 1'b1;
    for (int c = 5; c < 8; c++) begin
      fmt = 3'(c); in_pix = PIX; in_valid = 1'b1;
      #1 chk("R9 err flag", 32'(cfg_err), 32'd1);
      chk("R9 in_ready", 32'(in_ready), 32'd0);
      @(negedge clk);
      chk("R9 no output", 32'(out_valid), 32'd0);
    end
    fmt = 3'd0; in_valid = 1'b0;
    #1 chk("R9 err clear", 32'(cfg_err), 32'd0);
  endtask

  task automatic t_stall;
    @(negedge clk);
    fmt = 3'd0; in_pix = PIX; in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    in_pix = 32'h01020304;
    for (int i = 0; i < 3; i++) begin
      chk("R10 stall valid", 32'(out_valid), 32'd1);
      chk("R10 stall data", out_data, 32'hC8F08818);
      chk("R10 stall ready", 32'(in_ready), 32'd0);
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10 next word", out_data, 32'h01020304);
    @(negedge clk);
    chk("R10 drained", 32'(out_valid), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_formats();
    t_adjust();
    t_fill();
    t_cfg_err();
    t_stall();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule